// File: doc/BRIEF.md
# Spread-Spectrum Modem Serial Data Port

This block is the modem end of a full-duplex, synchronous, bit-serial data link with modem-style handshakes. It generates two serial clocks from the system clock: one paces bits from the host, and one paces bits to the host. A host raises its send request (active low). The block answers with a clear-to-send (active low). From then on it captures one transmit bit on each rising edge of the transmit clock and hands that bit to the modulator as a one-cycle valid/data pulse.

On the receive side, demodulated bits arrive as a valid/data stream and are held in a small FIFO. A carrier indication from the demodulator becomes an active-low carrier-detect output. Once carrier-detect is low, the block shifts buffered bits onto the receive line, one per falling edge of the receive clock. A select input sets when valid data starts: on the first or on the eighth falling edge after carrier-detect asserts. Until then the line is held at 1.

Everything runs in one system clock domain. The serial clocks are registered levels, and the rise and fall strobes of those clocks drive all sampling and output updates.

Top module: `ssm_serial_port`

## Requirements
- R1: `rxd` changes only in the system cycle in which `sclk_rx` goes from 1 to 0, so a host can latch it on the rising edge of `sclk_rx`.
- R2: With `delay_sel` = 0, the first buffered bit appears on `rxd` on the first `sclk_rx` falling edge after the edge on which `dcd_n` went to 0.
- R3: With `delay_sel` = 1, the first buffered bit appears on the eighth `sclk_rx` falling edge after the edge on which `dcd_n` went to 0.
- R4: `rxd` is 1 while `dcd_n` is 1 and on every falling edge before valid data starts.
- R5: `cts_n` changes only on `sclk_rx` falling edges. It goes to 0 on the first such edge after `rts_n` has been sampled low on an `sclk_tx` rising edge, and it goes back to 1 on the first such edge after `rts_n` has been sampled high.
- R6: On each `sclk_tx` rising edge at which `cts_n` was already 0, `mod_valid` pulses for exactly one cycle, and `mod_bit` carries the `txd` level from just before that edge. Idle ones are forwarded like data. No pulse occurs at any other time.
- R7: `dcd_n` follows the inverse of `demod_carrier`, updated on `sclk_rx` falling edges. On the edge where `dcd_n` returns to 1, `rxd` becomes 1, the start-delay count restarts, and any buffered bits are discarded.
- R8: Bits written with `demod_valid` are delivered in arrival order. The FIFO holds 16 bits, and writes made while it is full are dropped.
- R9: When the FIFO is empty at a delivery edge, `rxd` is 1.
- R10: Each serial clock stays in each level for the programmed half-period value in system cycles. A value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_half | input | 8 | Transmit clock half-period in system cycles |
| rx_half | input | 8 | Receive clock half-period in system cycles |
| delay_sel | input | 1 | 0: data from first falling edge; 1: from eighth |
| rts_n | input | 1 | Host send request, active low |
| txd | input | 1 | Host transmit bit |
| sclk_tx | output | 1 | Transmit serial clock |
| cts_n | output | 1 | Clear-to-send, active low |
| sclk_rx | output | 1 | Receive serial clock |
| dcd_n | output | 1 | Carrier detect, active low |
| rxd | output | 1 | Received bit to host |
| demod_valid | input | 1 | Demodulator bit strobe |
| demod_bit | input | 1 | Demodulator bit value |
| demod_carrier | input | 1 | Demodulator carrier present |
| mod_valid | output | 1 | Transmit bit strobe to modulator |
| mod_bit | output | 1 | Transmit bit value to modulator |

## Verification
The hardest situation to reach from the ports is a carrier loss in the middle of a burst. That is the moment where the delay count, the clamp and the FIFO contents must all be reset together. The stimulus preloads bits, lets a few of them out, and drops the carrier. It then raises the carrier again with nothing written and expects only ones, which shows that the stale bits were discarded. A long-delay burst run after earlier bursts confirms that the count restarted, because its first bit must land exactly on the eighth edge.

// File: rtl/ssm_pkg.sv
// Shared types for the serial data port.
package ssm_pkg;
    // One-cycle strobes announcing a serial clock edge at the next system edge.
    typedef struct packed {
        logic rise;
        logic fall;
    } ssm_strobe_t;
endpackage

// File: rtl/ssm_clkdiv.sv
// Serial clock generator. Toggles sclk every half_per system cycles (0 counts
// as 1). Assumes half_per is held steady while running. The strobes are high
// in the cycle whose closing edge moves sclk, so logic that acts on a strobe
// updates in the same edge as the serial clock.
module ssm_clkdiv
    import ssm_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_per,
    output logic             sclk,
    output ssm_strobe_t      stb
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;
    logic             wrap;

    // Terminal count for one half period.
    always_comb begin
        lim  = (half_per == '0) ? '0 : half_per - 1'b1;
        wrap = (cnt >= lim);
        stb.rise = wrap & ~sclk;
        stb.fall = wrap & sclk;
    end

    // Half-period counter and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ssm_fifo.sv
// Small synchronous FIFO. Pushes while full and pops while empty are ignored.
// Flush empties it and wins over push and pop. dout shows the oldest entry.
module ssm_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   level;
    logic          do_push, do_pop;

    // Qualify requests against occupancy.
    always_comb begin
        empty   = (level == '0);
        full    = (level == (AW+1)'(DEPTH));
        do_push = push & ~full;
        do_pop  = pop & ~empty;
        dout    = mem[rd_ptr];
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= din;
    end

    // Pointer and level tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            level <= level + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/ssm_rx_path.sv
// Receive side. Buffers demodulator bits, tracks carrier-detect on receive
// falling edges, and drives rxd once the selected start delay has passed.
// Assumes fall_stb comes from the receive clock generator.
module ssm_rx_path #(
    parameter int DEPTH     = 16,
    parameter int LONG_DLY  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_stb,
    input  logic delay_sel,
    input  logic demod_valid,
    input  logic demod_bit,
    input  logic demod_carrier,
    output logic dcd_n,
    output logic rxd
);
    localparam int CW = (LONG_DLY > 2) ? $clog2(LONG_DLY) : 1;
    localparam logic [CW-1:0] LAST = CW'(LONG_DLY - 1);

    logic [CW-1:0] edge_cnt;
    logic [CW-1:0] need;
    logic          ready, active, pop, flush, empty, full, head;

    // Start gate: edge index edge_cnt+1 must reach 1 or LONG_DLY.
    always_comb begin
        need   = delay_sel ? LAST : '0;
        ready  = (edge_cnt >= need);
        active = fall_stb & demod_carrier & ~dcd_n;
        pop    = active & ready;
        flush  = fall_stb & ~demod_carrier & ~dcd_n;
    end

    ssm_fifo #(.DEPTH(DEPTH), .W(1)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (demod_valid),
        .din   (demod_bit),
        .pop   (pop),
        .flush (flush),
        .dout  (head),
        .empty (empty),
        .full  (full)
    );

    // Carrier-detect, delay count and receive line, all on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcd_n    <= 1'b1;
            rxd      <= 1'b1;
            edge_cnt <= '0;
        end else if (fall_stb) begin
            if (!demod_carrier) begin
                dcd_n    <= 1'b1;
                rxd      <= 1'b1;
                edge_cnt <= '0;
            end else begin
                dcd_n <= 1'b0;
                if (active) begin
                    rxd <= (ready && !empty) ? head : 1'b1;
                    if (edge_cnt != LAST) edge_cnt <= edge_cnt + 1'b1;
                end else begin
                    rxd <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ssm_tx_path.sv
// Transmit side. Samples the send request on transmit rising edges, answers
// with clear-to-send on receive falling edges, and forwards each captured bit
// to the modulator as a one-cycle pulse.
module ssm_tx_path (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_stb,
    input  logic fall_stb,
    input  logic rts_n,
    input  logic txd,
    output logic cts_n,
    output logic mod_valid,
    output logic mod_bit
);
    logic req_seen;

    // Request sampling on transmit rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n)        req_seen <= 1'b0;
        else if (rise_stb) req_seen <= ~rts_n;
    end

    // Clear-to-send update on receive falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n)        cts_n <= 1'b1;
        else if (fall_stb) cts_n <= ~req_seen;
    end

    // Bit capture while clear-to-send is already granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_valid <= 1'b0;
            mod_bit   <= 1'b0;
        end else begin
            mod_valid <= rise_stb & ~cts_n;
            if (rise_stb && !cts_n) mod_bit <= txd;
        end
    end
endmodule

// File: rtl/ssm_serial_port.sv
// Modem-side serial data port: two serial clock generators, a transmit
// handshake/capture path and a buffered receive path with selectable start
// delay. Single clock domain, synchronous active-low reset.
module ssm_serial_port
    import ssm_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int LONG_DELAY = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] tx_half,
    input  logic [DIV_W-1:0] rx_half,
    input  logic             delay_sel,
    input  logic             rts_n,
    input  logic             txd,
    output logic             sclk_tx,
    output logic             cts_n,
    output logic             sclk_rx,
    output logic             dcd_n,
    output logic             rxd,
    input  logic             demod_valid,
    input  logic             demod_bit,
    input  logic             demod_carrier,
    output logic             mod_valid,
    output logic             mod_bit
);
    localparam int NCLK = 2;   // index 0: transmit, 1: receive

    logic [DIV_W-1:0] half   [NCLK];
    logic             sclk   [NCLK];
    ssm_strobe_t      stb    [NCLK];

    // Route programmed half-periods to the generators.
    always_comb begin
        half[0] = tx_half;
        half[1] = rx_half;
    end

    for (genvar g = 0; g < NCLK; g++) begin : g_div
        ssm_clkdiv #(.DIV_W(DIV_W)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .half_per (half[g]),
            .sclk     (sclk[g]),
            .stb      (stb[g])
        );
    end

    assign sclk_tx = sclk[0];
    assign sclk_rx = sclk[1];

    ssm_tx_path u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_stb  (stb[0].rise),
        .fall_stb  (stb[1].fall),
        .rts_n     (rts_n),
        .txd       (txd),
        .cts_n     (cts_n),
        .mod_valid (mod_valid),
        .mod_bit   (mod_bit)
    );

    ssm_rx_path #(.DEPTH(FIFO_DEPTH), .LONG_DLY(LONG_DELAY)) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .fall_stb      (stb[1].fall),
        .delay_sel     (delay_sel),
        .demod_valid   (demod_valid),
        .demod_bit     (demod_bit),
        .demod_carrier (demod_carrier),
        .dcd_n         (dcd_n),
        .rxd           (rxd)
    );
endmodule

// File: rtl/ssm_serial_port_chk.sv
// Port-level protocol checker for ssm_serial_port, attached by bind.
module ssm_serial_port_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk_tx,
    input logic sclk_rx,
    input logic cts_n,
    input logic dcd_n,
    input logic rxd,
    input logic mod_valid
);
    // R1: receive line moves only with a receive falling edge.
    assert_rxd_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rxd) |-> $fell(sclk_rx));

    // R4: line clamped high while carrier-detect is inactive.
    assert_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dcd_n |-> rxd);

    // R5: clear-to-send moves only with a receive falling edge.
    assert_cts_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cts_n) |-> $fell(sclk_rx));

    // R6: capture only on a transmit rising edge with clear-to-send granted.
    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mod_valid |-> ($rose(sclk_tx) && !$past(cts_n)));

    // R7: carrier-detect moves only with a receive falling edge.
    assert_dcd_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dcd_n) |-> $fell(sclk_rx));
endmodule

bind ssm_serial_port ssm_serial_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_tx   (sclk_tx),
    .sclk_rx   (sclk_rx),
    .cts_n     (cts_n),
    .dcd_n     (dcd_n),
    .rxd       (rxd),
    .mod_valid (mod_valid)
);

// File: tb/ssm_serial_port_tb.sv
// Directed bench for ssm_serial_port: one task per scenario.
module ssm_serial_port_tb;
    localparam int TXH = 2;
    localparam int RXH = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_half = 8'(TXH);
    logic [7:0] rx_half = 8'(RXH);
    logic       delay_sel = 1'b0;
    logic       rts_n = 1'b1;
    logic       txd = 1'b1;
    logic       demod_valid = 1'b0;
    logic       demod_bit = 1'b0;
    logic       demod_carrier = 1'b0;
    logic       sclk_tx, cts_n, sclk_rx, dcd_n, rxd, mod_valid, mod_bit;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ssm_serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .tx_half(tx_half), .rx_half(rx_half),
        .delay_sel(delay_sel), .rts_n(rts_n), .txd(txd),
        .sclk_tx(sclk_tx), .cts_n(cts_n), .sclk_rx(sclk_rx), .dcd_n(dcd_n),
        .rxd(rxd), .demod_valid(demod_valid), .demod_bit(demod_bit),
        .demod_carrier(demod_carrier), .mod_valid(mod_valid), .mod_bit(mod_bit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait until the next receive falling edge has taken effect.
    task automatic wait_rx_fall();
        logic p;
        p = sclk_rx;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (p && !sclk_rx) return;
            p = sclk_rx;
        end
    endtask

    task automatic push_bit(input logic b);
        demod_valid = 1'b1;
        demod_bit   = b;
        @(negedge clk);
        demod_valid = 1'b0;
    endtask

    // R10: receive clock period equals twice the half-period.
    task automatic t_divider();
        int c;
        wait_rx_fall();
        c = 0;
        begin : cnt_loop
            logic p;
            p = sclk_rx;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                c++;
                if (p && !sclk_rx) disable cnt_loop;
                p = sclk_rx;
            end
        end
        chk(c == 2 * RXH, "R10 period", c, 2 * RXH);
    endtask

    // R2/R3/R4/R8/R9/R7: one receive burst, then carrier removal.
    task automatic run_rx(input bit dsel, input logic [31:0] pat, input int npush);
        int stored, n, last;
        string tag;
        delay_sel = dsel;
        for (int i = 0; i < npush; i++) push_bit(pat[i]);
        stored = (npush > 16) ? 16 : npush;
        demod_carrier = 1'b1;
        for (int i = 0; i < 10 && dcd_n; i++) wait_rx_fall();
        chk(dcd_n == 1'b0, "R7 dcd assert", dcd_n, 0);
        chk(rxd == 1'b1, "R4 clamp at assert", rxd, 1);
        n = dsel ? 8 : 1;
        last = n - 1 + stored + 2;
        for (int k = 1; k <= last; k++) begin
            logic e;
            wait_rx_fall();
            if (k < n) begin
                e = 1'b1; tag = "R4 before start";
            end else if (k - n < stored) begin
                e = pat[k - n];
                tag = (k == n) ? (dsel ? "R3 first bit" : "R2 first bit") : "R8 order";
            end else begin
                e = 1'b1; tag = "R9 underflow";
            end
            chk(rxd == e, tag, rxd, e);
        end
        demod_carrier = 1'b0;
        wait_rx_fall();
        chk(dcd_n == 1'b1 && rxd == 1'b1, "R7 deassert clamp", {dcd_n, rxd}, 3);
    endtask

    // R7: carrier loss mid-burst discards buffered bits.
    task automatic t_flush();
        delay_sel = 1'b0;
        for (int i = 0; i < 6; i++) push_bit(1'b0);
        demod_carrier = 1'b1;
        for (int i = 0; i < 10 && dcd_n; i++) wait_rx_fall();
        wait_rx_fall();
        chk(rxd == 1'b0, "R2 flush pre", rxd, 0);
        wait_rx_fall();
        demod_carrier = 1'b0;
        wait_rx_fall();
        chk(dcd_n == 1'b1 && rxd == 1'b1, "R7 drop", {dcd_n, rxd}, 3);
        demod_carrier = 1'b1;
        for (int i = 0; i < 10 && dcd_n; i++) wait_rx_fall();
        for (int k = 1; k <= 4; k++) begin
            wait_rx_fall();
            chk(rxd == 1'b1, "R7 flushed", rxd, 1);
        end
        demod_carrier = 1'b0;
        wait_rx_fall();
    endtask

    // R5/R6: handshake, idle ones, data, release.
    task automatic t_handshake();
        logic [7:0] pat = 8'b1100_1010;
        logic p_tx, p_rx, seen, cts_exp, old_seen, old_cts, rtx, frx, ev;
        int cap = 0;
        int cts_fall_seen = 0;
        txd = 1'b1;
        rts_n = 1'b0;
        seen = 1'b0; cts_exp = 1'b1;
        p_tx = sclk_tx; p_rx = sclk_rx;
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            rtx = !p_tx && sclk_tx;
            frx = p_rx && !sclk_rx;
            old_seen = seen; old_cts = cts_exp;
            if (rtx) seen = !rts_n;
            if (frx) cts_exp = !old_seen;
            if (frx) begin
                chk(cts_n == cts_exp, "R5 cts", cts_n, cts_exp);
                if (!cts_exp && old_cts) cts_fall_seen++;
            end
            ev = rtx && !old_cts;
            if (rtx || mod_valid) chk(mod_valid == ev, "R6 valid", mod_valid, ev);
            if (ev) begin
                chk(mod_bit == txd, "R6 bit", mod_bit, txd);
                cap++;
                txd = (cap >= 2 && cap - 2 < 8) ? pat[cap - 2] : 1'b1;
                if (cap == 10) rts_n = 1'b1;
            end
            p_tx = sclk_tx; p_rx = sclk_rx;
        end
        chk(cap >= 10, "R6 captures", cap, 10);
        chk(cts_fall_seen == 1, "R5 grant", cts_fall_seen, 1);
        chk(cts_n == 1'b1, "R5 release", cts_n, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cts_n == 1 && dcd_n == 1 && rxd == 1 && mod_valid == 0, "R4 reset",
            {cts_n, dcd_n, rxd, mod_valid}, 14);
        t_divider();
        run_rx(1'b0, 32'h0000_00B2, 8);
        run_rx(1'b1, 32'h0000_03A5, 10);
        run_rx(1'b0, 32'h000F_3A5C, 20);
        t_flush();
        run_rx(1'b1, 32'h0000_0036, 6);
        t_handshake();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule